// File: doc/BRIEF.md
# Burst SRAM cycle controller

This block sits in front of a small synchronous memory and decides, on every rising clock edge, what kind of cycle the memory runs next. It samples three chip selects (primary active-low, one active-high, one active-low), two address strobes, an advance input and the write inputs: a global write, a byte-write enable and four per-byte enables. From these it picks one of five outcomes: idle, deselect, burst start, burst step or burst hold.

The processor strobe only counts while the primary chip select is low, and it always opens a read burst. The controller strobe can open a read or a write burst, as the write inputs decode. While both strobes are high, the advance input steps a 2-bit burst offset or holds it. A step wraps within a group of four words, and the upper address bits stay fixed. The block registers the load strobe, the step strobe, the read/write mode, a per-lane write mask and the current word address. It also holds a 16-word, 36-bit array whose four 9-bit lanes are written under that mask.

Top module: `bsram_cycle_ctrl`

## Requirements
- R1: While rst_ni is low, sel_o, ld_o, adv_o and wr_o are 0 and bmask_o is 0.
- R2: If strb_cpu_ni is low and all three chip selects are active (csa_ni=0, csb_i=1, csc_ni=0), the next cycle has ld_o=1, sel_o=1, wr_o=0 and bmask_o=0, and addr_o equals addr_i, whatever the write inputs are.
- R3: If csa_ni is high, strb_cpu_ni has no effect. The cycle then follows strb_ctl_ni, or follows the advance rules when strb_ctl_ni is high.
- R4: If the processor strobe is not in effect, strb_ctl_ni is low and all chip selects are active, the next cycle has ld_o=1 and sel_o=1, addr_o equals addr_i, and the mode is the decoded write.
- R5: A strobe start (R2 or R4 condition without the chip-select part) with any chip select inactive gives sel_o=0 and ld_o=0 in the next cycle.
- R6: With both strobes out of effect, sel_o=1 and adv_ni low, the next cycle has adv_o=1. The low two bits of addr_o step +1 modulo 4 (linear order), and the upper two bits stay unchanged.
- R7: Under the same strobe condition with adv_ni high, the next cycle has adv_o=0 and the same addr_o.
- R8: gw_ni low makes bmask_o 4'b1111 and wr_o 1 in the next active cycle (except for a processor start), regardless of bwe_ni and bye_ni.
- R9: With gw_ni high and bwe_ni low, bmask_o[i] = ~bye_ni[i]. wr_o is 1 exactly when bmask_o is nonzero, so all bye_ni high gives a read.
- R10: With gw_ni and bwe_ni both high, the cycle is a read (wr_o=0, bmask_o=0).
- R11: Chip selects are sampled only at strobe starts, so changing them during step or hold cycles leaves sel_o at 1.
- R12: rdata_o shows word addr_o of the array. In a write cycle, the edge that ends the cycle stores wdata_i lane i (bits 9i+8..9i) where bmask_o[i] is 1.
- R13: While sel_o is 0, adv_o and wr_o are 0 and no array word changes. With no strobe start it stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| csa_ni | input | 1 | Primary chip select, active low; gates the processor strobe |
| csb_i | input | 1 | Chip select, active high |
| csc_ni | input | 1 | Chip select, active low |
| strb_cpu_ni | input | 1 | Processor address strobe, active low |
| strb_ctl_ni | input | 1 | Controller address strobe, active low |
| adv_ni | input | 1 | Burst advance, active low |
| gw_ni | input | 1 | Global write, active low |
| bwe_ni | input | 1 | Byte-write enable, active low |
| bye_ni | input | 4 | Per-lane write enables, active low |
| addr_i | input | 4 | External word address; bits 1:0 are the burst offset |
| wdata_i | input | 36 | Write data, four 9-bit lanes |
| ld_o | output | 1 | Address was loaded for this cycle |
| adv_o | output | 1 | Burst offset was stepped for this cycle |
| wr_o | output | 1 | This cycle is a write |
| sel_o | output | 1 | Device selected |
| bmask_o | output | 4 | Lane write mask of this cycle |
| addr_o | output | 4 | Word address of this cycle |
| rdata_o | output | 36 | Array word at addr_o |

## Verification
Two things can land on the same edge. The write of the cycle that is ending commits to the array on the edge that also decodes the next cycle, which can be a new start or a step to a neighbouring word. Random runs create this by following write bursts at once with starts, steps and reads of the same group. Every rdata_o is compared against a bench array that applies the old write before it moves the address. Directed cases put a processor start, which must stay a read, on the cycle right after a write, and toggle chip selects in the middle of a burst.

// File: rtl/bsc_pkg.sv
package bsc_pkg;
  typedef enum logic [2:0] {
    CYC_IDLE,
    CYC_DESEL,
    CYC_START,
    CYC_STEP,
    CYC_HOLD
  } cyc_e;
endpackage

// File: rtl/bsc_decode.sv
module bsc_decode
  import bsc_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             csa_ni,
  input  logic             csb_i,
  input  logic             csc_ni,
  input  logic             strb_cpu_ni,
  input  logic             strb_ctl_ni,
  input  logic             adv_ni,
  input  logic             gw_ni,
  input  logic             bwe_ni,
  input  logic [LANES-1:0] bye_ni,
  input  logic             sel_q_i,
  output cyc_e             kind_o,
  output logic             load_o,
  output logic             step_o,
  output logic             sel_d_o,
  output logic [LANES-1:0] mask_d_o
);
  logic cs_ok, cpu_go, ctl_go, start;
  logic [LANES-1:0] wr_mask;

  assign cs_ok  = !csa_ni && csb_i && !csc_ni;
  assign cpu_go = !strb_cpu_ni && !csa_ni;      // primary select gates cpu strobe
  assign ctl_go = !cpu_go && !strb_ctl_ni;
  assign start  = cpu_go || ctl_go;

  always_comb begin
    if (!gw_ni)       wr_mask = '1;
    else if (!bwe_ni) wr_mask = ~bye_ni;
    else              wr_mask = '0;
  end

  always_comb begin
    if (start)        kind_o = cs_ok ? CYC_START : CYC_DESEL;
    else if (!sel_q_i) kind_o = CYC_IDLE;
    else if (!adv_ni) kind_o = CYC_STEP;
    else              kind_o = CYC_HOLD;
  end

  assign load_o   = (kind_o == CYC_START);
  assign step_o   = (kind_o == CYC_STEP);
  assign sel_d_o  = (kind_o == CYC_START) || (kind_o == CYC_STEP) || (kind_o == CYC_HOLD);
  assign mask_d_o = (!sel_d_o || (cpu_go && cs_ok)) ? '0 : wr_mask;
endmodule

// File: rtl/bsc_counter.sv
module bsc_counter #(
  parameter int BURST_W = 2,
  parameter bit ILV     = 1'b0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic               step_i,
  input  logic [BURST_W-1:0] base_i,
  output logic [BURST_W-1:0] off_o
);
  logic [BURST_W-1:0] base_q, cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      cnt_q  <= '0;
    end else if (load_i) begin
      base_q <= base_i;
      cnt_q  <= '0;
    end else if (step_i) begin
      cnt_q  <= cnt_q + 1'b1;   // wraps to the first word
    end
  end

  generate
    if (ILV) begin : g_ilv
      assign off_o = base_q ^ cnt_q;
    end else begin : g_lin
      assign off_o = base_q + cnt_q;
    end
  endgenerate
endmodule

// File: rtl/bsc_mem.sv
module bsc_mem #(
  parameter int AW     = 4,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int DW    = LANES * LANE_W,
  localparam int DEPTH = 1 << AW
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [LANES-1:0] mask_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int w = 0; w < DEPTH; w++) mem_q[w] <= '0;
    end else if (we_i) begin
      for (int l = 0; l < LANES; l++)
        if (mask_i[l]) mem_q[addr_i][l*LANE_W +: LANE_W] <= wdata_i[l*LANE_W +: LANE_W];
    end
  end

  assign rdata_o = mem_q[addr_i];
endmodule

// File: rtl/bsram_cycle_ctrl.sv
module bsram_cycle_ctrl
  import bsc_pkg::*;
#(
  parameter int UPPER_W = 2,
  parameter int BURST_W = 2,
  parameter int LANES   = 4,
  parameter int LANE_W  = 9,
  parameter bit ILV     = 1'b0,
  localparam int AW     = UPPER_W + BURST_W,
  localparam int DW     = LANES * LANE_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             csa_ni,
  input  logic             csb_i,
  input  logic             csc_ni,
  input  logic             strb_cpu_ni,
  input  logic             strb_ctl_ni,
  input  logic             adv_ni,
  input  logic             gw_ni,
  input  logic             bwe_ni,
  input  logic [LANES-1:0] bye_ni,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    wdata_i,
  output logic             ld_o,
  output logic             adv_o,
  output logic             wr_o,
  output logic             sel_o,
  output logic [LANES-1:0] bmask_o,
  output logic [AW-1:0]    addr_o,
  output logic [DW-1:0]    rdata_o
);
  cyc_e               kind;
  logic               load, step, sel_d;
  logic [LANES-1:0]   mask_d;
  logic               sel_q, ld_q, adv_q;
  logic [LANES-1:0]   mask_q;
  logic [UPPER_W-1:0] upper_q;
  logic [BURST_W-1:0] off;

  bsc_decode #(.LANES(LANES)) u_dec (
    .csa_ni, .csb_i, .csc_ni, .strb_cpu_ni, .strb_ctl_ni, .adv_ni,
    .gw_ni, .bwe_ni, .bye_ni,
    .sel_q_i (sel_q),
    .kind_o  (kind),
    .load_o  (load),
    .step_o  (step),
    .sel_d_o (sel_d),
    .mask_d_o(mask_d)
  );

  bsc_counter #(.BURST_W(BURST_W), .ILV(ILV)) u_cnt (
    .clk_i, .rst_ni,
    .load_i(load),
    .step_i(step),
    .base_i(addr_i[BURST_W-1:0]),
    .off_o (off)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q   <= 1'b0;
      ld_q    <= 1'b0;
      adv_q   <= 1'b0;
      mask_q  <= '0;
      upper_q <= '0;
    end else begin
      sel_q  <= sel_d;
      ld_q   <= load;
      adv_q  <= step;
      mask_q <= mask_d;
      if (load) upper_q <= addr_i[AW-1:BURST_W];
    end
  end

  assign addr_o  = {upper_q, off};
  assign ld_o    = ld_q;
  assign adv_o   = adv_q;
  assign sel_o   = sel_q;
  assign bmask_o = mask_q;
  assign wr_o    = |mask_q;

  bsc_mem #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) u_mem (
    .clk_i, .rst_ni,
    .we_i   (sel_q && wr_o),
    .mask_i (mask_q),
    .addr_i (addr_o),
    .wdata_i(wdata_i),
    .rdata_o(rdata_o)
  );
endmodule

// File: rtl/bsram_cycle_ctrl_chk.sv
module bsram_cycle_ctrl_chk #(
  parameter int UPPER_W = 2,
  parameter int BURST_W = 2,
  parameter int LANES   = 4,
  localparam int AW     = UPPER_W + BURST_W
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             csa_ni,
  input logic             csb_i,
  input logic             csc_ni,
  input logic             strb_cpu_ni,
  input logic             strb_ctl_ni,
  input logic             adv_ni,
  input logic             gw_ni,
  input logic             ld_o,
  input logic             adv_o,
  input logic             wr_o,
  input logic             sel_o,
  input logic [LANES-1:0] bmask_o,
  input logic [AW-1:0]    addr_o
);
  logic cs_ok, cpu_go, ctl_go, hold;
  assign cs_ok  = !csa_ni && csb_i && !csc_ni;
  assign cpu_go = !strb_cpu_ni && !csa_ni;
  assign ctl_go = !cpu_go && !strb_ctl_ni;
  assign hold   = !cpu_go && strb_ctl_ni;

  AST_RESET_QUIET: assert property (@(posedge clk_i) !rst_ni |-> !sel_o && !ld_o && !adv_o && bmask_o == '0); // R1
  AST_CPU_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_go && cs_ok |=> ld_o && sel_o && !wr_o && bmask_o == '0); // R2
  AST_CTL_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_go && cs_ok |=> ld_o && sel_o); // R4
  AST_DESEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_go || ctl_go) && !cs_ok |=> !sel_o && !ld_o); // R5
  AST_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold && sel_o && !adv_ni |=> adv_o && sel_o && addr_o[AW-1:BURST_W] == $past(addr_o[AW-1:BURST_W])); // R6
  AST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold && sel_o && adv_ni |=> !adv_o && sel_o && $stable(addr_o)); // R7
  AST_GW_ALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gw_ni && ((ctl_go && cs_ok) || (hold && sel_o)) |=> wr_o && bmask_o == '1); // R8
  AST_MODE_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_o == (bmask_o != '0)); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_o |-> !wr_o && !adv_o); // R13
endmodule

bind bsram_cycle_ctrl bsram_cycle_ctrl_chk #(
  .UPPER_W(UPPER_W), .BURST_W(BURST_W), .LANES(LANES)
) u_chk (.*);

// File: tb/bsram_cycle_ctrl_tb.sv
`timescale 1ns/1ps
module bsram_cycle_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic csa_n = 1'b1, csb = 1'b0, csc_n = 1'b1;
  logic sp_n = 1'b1, sc_n = 1'b1, adv_n = 1'b1, gw_n = 1'b1, bwe_n = 1'b1;
  logic [3:0]  bye_n = 4'hF;
  logic [3:0]  addr = '0;
  logic [35:0] wdata = '0;
  logic ld, adv, wr, sel;
  logic [3:0]  bmask, addr_q;
  logic [35:0] rdata;

  int checks = 0, errors = 0;
  bit done = 0;

  // bench model state
  logic m_sel = 0, m_ld = 0, m_adv = 0;
  logic [3:0] m_mask = '0;
  logic [1:0] m_up = '0, m_base = '0, m_cnt = '0;
  logic [35:0] m_mem [16];
  string t_cyc, t_mask;

  always #10 clk = ~clk;

  bsram_cycle_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .csa_ni(csa_n), .csb_i(csb), .csc_ni(csc_n),
    .strb_cpu_ni(sp_n), .strb_ctl_ni(sc_n), .adv_ni(adv_n), .gw_ni(gw_n),
    .bwe_ni(bwe_n), .bye_ni(bye_n), .addr_i(addr), .wdata_i(wdata),
    .ld_o(ld), .adv_o(adv), .wr_o(wr), .sel_o(sel), .bmask_o(bmask),
    .addr_o(addr_q), .rdata_o(rdata)
  );

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [3:0] m_addr();
    return {m_up, m_base + m_cnt};
  endfunction

  task automatic model_edge();
    logic cs_ok, cpu_go, ctl_go, start;
    logic [3:0] wm;
    if (m_sel && m_mask != 0)  // R12: commit the ending write
      for (int l = 0; l < 4; l++)
        if (m_mask[l]) m_mem[m_addr()][l*9 +: 9] = wdata[l*9 +: 9];
    cs_ok  = !csa_n && csb && !csc_n;
    cpu_go = !sp_n && !csa_n;
    ctl_go = !cpu_go && !sc_n;
    start  = cpu_go || ctl_go;
    wm = !gw_n ? 4'hF : (!bwe_n ? ~bye_n : 4'h0);
    t_mask = !gw_n ? "R8" : (!bwe_n ? "R9" : "R10");
    m_ld = 0; m_adv = 0;
    if (start) begin
      if (cs_ok) begin
        m_sel = 1; m_ld = 1; m_up = addr[3:2]; m_base = addr[1:0]; m_cnt = 0;
        m_mask = cpu_go ? 4'h0 : wm;
        t_cyc = cpu_go ? "R2" : (!sp_n ? "R3" : "R4");
        if (cpu_go) t_mask = "R2";
      end else begin
        m_sel = 0; m_mask = 0; t_cyc = "R5";
      end
    end else if (m_sel) begin
      if (!adv_n) begin m_adv = 1; m_cnt = m_cnt + 1; t_cyc = "R6"; end
      else t_cyc = "R7";
      if (!cs_ok) t_cyc = "R11";
      else if (!sp_n) t_cyc = "R3";
      m_mask = wm;
    end else begin
      m_mask = 0; t_cyc = "R13";
    end
  endtask

  task automatic cyc(input logic ca, cb, cc, sp, sc, ad, g, b, input logic [3:0] be,
                     input logic [3:0] a, input logic [35:0] wd);
    csa_n = ca; csb = cb; csc_n = cc; sp_n = sp; sc_n = sc; adv_n = ad;
    gw_n = g; bwe_n = b; bye_n = be; addr = a; wdata = wd;
    model_edge();
    @(posedge clk);
    @(negedge clk);
    chk(t_cyc, "sel", sel, m_sel);
    chk(t_cyc, "ld", ld, m_ld);
    chk(t_cyc, "adv", adv, m_adv);
    chk(t_cyc, "addr", addr_q, m_addr());
    chk(t_mask, "bmask", bmask, m_mask);
    chk(t_mask, "wr", wr, m_mask != 0);
    chk("R12", "rdata", rdata, m_mem[m_addr()]);
  endtask

  // shorthand: all selects active
  task automatic go(input logic sp, sc, ad, g, b, input logic [3:0] be, input logic [3:0] a, input logic [35:0] wd);
    cyc(1'b0, 1'b1, 1'b0, sp, sc, ad, g, b, be, a, wd);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) m_mem[i] = '0;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk("R1", "sel", sel, 0); chk("R1", "ld", ld, 0); chk("R1", "adv", adv, 0);
    chk("R1", "wr", wr, 0);   chk("R1", "bmask", bmask, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // idle with strobes high
    go(1, 1, 0, 0, 0, 4'h0, 4'h0, 36'h0);
    // R8: controller write burst with gw low, start at offset 2, wrap
    go(1, 0, 1, 0, 1, 4'hF, 4'h6, 36'h0);
    go(1, 1, 0, 0, 1, 4'hF, 4'h0, 36'h111111111);
    go(1, 1, 0, 0, 1, 4'hF, 4'h0, 36'h222222222);
    go(1, 1, 0, 0, 1, 4'hF, 4'h0, 36'h333333333);
    go(1, 1, 0, 0, 1, 4'hF, 4'h0, 36'h444444444);  // R6 wrap back to offset 2
    // R7 hold, then byte write lanes 0 and 2 (R9)
    go(1, 1, 1, 1, 0, 4'b1010, 4'h0, 36'h555555555);
    go(1, 1, 1, 1, 1, 4'hF, 4'h0, 36'hABCDEF123);
    // R2: processor start with gw low stays a read
    go(0, 1, 1, 0, 0, 4'h0, 4'h5, 36'h0);
    go(1, 1, 0, 1, 1, 4'hF, 4'h0, 36'h0);
    // R11: selects drop mid-burst
    cyc(1, 0, 1, 1, 1, 0, 1, 1, 4'hF, 4'h0, 36'h0);
    cyc(1, 0, 1, 0, 1, 1, 1, 1, 4'hF, 4'h0, 36'h0);
    // R3: primary select high blocks the processor strobe
    cyc(1, 1, 0, 0, 1, 0, 1, 1, 4'hF, 4'hC, 36'h0);
    // R9 all per-lane high -> read via controller
    go(1, 0, 1, 1, 0, 4'hF, 4'h9, 36'h0);
    // R5: controller strobe with csb low deselects
    cyc(0, 0, 0, 1, 0, 1, 0, 1, 4'hF, 4'h3, 36'h0);
    // R13: idle, write inputs active, nothing changes
    go(1, 1, 0, 0, 0, 4'h0, 4'h0, 36'hFFFFFFFFF);
    // R5 processor path with csc high
    cyc(0, 1, 1, 0, 1, 1, 1, 1, 4'hF, 4'h1, 36'h0);
    // random
    for (int n = 0; n < 4000; n++) begin
      logic [7:0] r;
      r = 8'($urandom);
      cyc(($urandom % 8) == 0, ($urandom % 8) != 0, ($urandom % 8) == 0,
          ($urandom % 6) != 0, ($urandom % 5) != 0, r[0],
          ($urandom % 4) != 0, r[1], 4'($urandom), 4'($urandom), 36'($urandom) ^ {36{r[2]}});
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule